// File: doc/BRIEF.md
# Hidden Region Protect Sequencer

This block decodes bus write cycles aimed at a small one-time hidden region while the region's access mode is held active. Two command sequences are recognised after a shared three-write prefix. One programs a word: programming can only clear bits, so the stored word becomes the old word ANDed with the new data. The other sets a permanent protect bit. A register array of `MEM_WORDS` words stands in for the region, and the words at index `REGION_WORDS` and above stand in for ordinary storage beyond it.

Protection takes two phases. A write of 48h as the fourth cycle starts a timed pulse. The pulse lasts `CLK_MHZ * TIMEOUT_US` clocks and holds `busy` high. A further 48h write then arms a verify. After that, each read returns the pass or fail result on data bit 0. A model parameter, `PROTECT_PULSES`, sets how many pulses the cell needs before it takes. Until then the verify reports a fail, and the host retries by writing 48h again, which starts a new pulse. While an operation runs, reads return completion status: bit 7 shows data polling and bit 6 toggles.

Top module: `hprot_seq`

## Requirements
- R1: After reset, `busy` and `protect_bit` are 0, `rdata` is 0000h, and every array word reads FFFFh.
- R2: While `mode_en` is 0, the sequencer is held idle. Writes program nothing and start nothing. If `mode_en` falls during an operation, `busy` is 0 from the following cycle and the operation has no effect.
- R3: The prefix is AAh at address 555h, then 55h at 2AAh, then A0h (program) or 60h (protect) at 555h, with data compared on bits 7:0. Any write that does not match returns the sequencer to idle, so a later fourth-cycle write has no effect.
- R4: A program fourth cycle captures `addr[3:0]` as the word index. `busy` then stays high for `PROG_CYCLES` clocks, after which that word equals its old value AND `wdata`.
- R5: While `busy` is high, writes are ignored. Each read then returns bit 7 = inverse of bit 7 of the data being programmed (0 during a protect pulse), bit 6 inverted from the previous busy read, and all other bits 0.
- R6: Programming a word whose index is `REGION_WORDS` or above changes that word, whether or not the region is protected.
- R7: In the protect sequence, a fourth-cycle write of 48h (any address) starts a pulse during which `busy` stays high for `CLK_MHZ * TIMEOUT_US` clocks.
- R8: After a pulse ends, a write of 48h arms the verify. Reads then return 0001h if `protect_bit` is 1 and 0000h otherwise.
- R9: `protect_bit` rises when the `PROTECT_PULSES`-th pulse ends and then stays 1. In the verify state, a further 48h write starts a new pulse, which is a retry from the fourth cycle.
- R10: Once `protect_bit` is 1, a program fourth cycle aimed at a region index (below `REGION_WORDS`) is ignored: `busy` stays 0 and the word is unchanged.
- R11: Reads are registered. `rdata` updates on the clock edge that samples `rd_en` and holds until the next read. Outside busy and verify, it returns the array word at `addr[3:0]`.
- R12: A write other than 48h where the verify-arming write is expected returns the sequencer to idle, so the next read returns array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Hidden region access mode active |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| rd_en | input | 1 | Read strobe, one cycle per bus read |
| addr | input | ADDR_W | Bus address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data or status |
| busy | output | 1 | A program or protect pulse is running |
| protect_bit | output | 1 | Region protect bit |

## Verification
A wrong sequencer state shows up first on `busy`. It rises on the edge after an accepted fourth cycle, or fails to rise, and the pulse length can be counted exactly in clocks. A wrong pulse count or verify decision shows up on the read after the arming write, as a bit-0 value that disagrees with `protect_bit`. A wrong array update or a wrong region lock only shows up when the word is read back. For that reason, every program operation in the bench is followed by a read of the affected word.

// File: rtl/hprot_pkg.sv
package hprot_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_UL1,
        S_UL2,
        S_PGM_ARG,
        S_PRT_ARG,
        S_PGM_RUN,
        S_PRT_RUN,
        S_PRT_ARMED,
        S_PRT_VFY
    } seq_st_e;

    localparam logic [10:0] A_FIRST  = 11'h555;
    localparam logic [10:0] A_SECOND = 11'h2AA;
    localparam logic [7:0]  D_FIRST  = 8'hAA;
    localparam logic [7:0]  D_SECOND = 8'h55;
    localparam logic [7:0]  D_PGM    = 8'hA0;
    localparam logic [7:0]  D_PRT    = 8'h60;
    localparam logic [7:0]  D_LOCK   = 8'h48;

endpackage

// File: rtl/hprot_decode.sv
module hprot_decode #(
    parameter int ADDR_W = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic              cyc1_ok,
    output logic              cyc2_ok,
    output logic              pgm_ok,
    output logic              prt_ok,
    output logic              lock_ok
);
    import hprot_pkg::*;

    logic [10:0] a_low;
    logic [7:0]  d_low;

    always_comb begin
        a_low   = addr[10:0];
        d_low   = wdata[7:0];
        cyc1_ok = (a_low == A_FIRST)  && (d_low == D_FIRST);
        cyc2_ok = (a_low == A_SECOND) && (d_low == D_SECOND);
        pgm_ok  = (a_low == A_FIRST)  && (d_low == D_PGM);
        prt_ok  = (a_low == A_FIRST)  && (d_low == D_PRT);
        lock_ok = (d_low == D_LOCK);
    end

endmodule

// File: rtl/hprot_timer.sv
module hprot_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
        zero = (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/hprot_array.sv
module hprot_array #(
    parameter int WORDS  = 16,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wval,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rword
);
    logic [DATA_W-1:0] mem_q [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic hit;
        assign hit = we && (widx == IDX_W'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   mem_q[g] <= '1;
            else if (hit) mem_q[g] <= mem_q[g] & wval;
        end
    end

    assign rword = mem_q[ridx];

endmodule

// File: rtl/hprot_rdport.sv
module hprot_rdport #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              show_poll,
    input  logic              show_vfy,
    input  logic              poll_bit,
    input  logic              vfy_bit,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rdata_d, rdata_q;
    logic              tog_d, tog_q;

    always_comb begin
        rdata_d = rdata_q;
        tog_d   = tog_q;
        if (rd_en) begin
            if (show_vfy) begin
                rdata_d    = '0;
                rdata_d[0] = vfy_bit;
            end else if (show_poll) begin
                rdata_d    = '0;
                rdata_d[7] = poll_bit;
                rdata_d[6] = tog_q;
                tog_d      = ~tog_q;
            end else begin
                rdata_d = word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            tog_q   <= 1'b0;
        end else begin
            rdata_q <= rdata_d;
            tog_q   <= tog_d;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/hprot_seq.sv
module hprot_seq #(
    parameter int ADDR_W         = 11,
    parameter int MEM_WORDS      = 16,
    parameter int REGION_WORDS   = 8,
    parameter int PROG_CYCLES    = 16,
    parameter int CLK_MHZ        = 100,
    parameter int TIMEOUT_US     = 150,
    parameter int PROTECT_PULSES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              busy,
    output logic              protect_bit
);
    import hprot_pkg::*;

    localparam int DATA_W  = 16;
    localparam int IDX_W   = $clog2(MEM_WORDS);
    localparam int PRT_LEN = CLK_MHZ * TIMEOUT_US;
    localparam int MAX_LEN = (PRT_LEN > PROG_CYCLES) ? PRT_LEN : PROG_CYCLES;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam int PW      = $clog2(PROTECT_PULSES + 1);
    localparam logic [IDX_W:0] REG_LIM   = (IDX_W+1)'(REGION_WORDS);
    localparam logic [PW-1:0]  PULSE_LIM = PW'(PROTECT_PULSES);

    typedef struct packed {
        seq_st_e           st;
        logic [PW-1:0]     pulses;
        logic              prot;
        logic [IDX_W-1:0]  tgt_idx;
        logic [DATA_W-1:0] tgt_val;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             cyc1_ok, cyc2_ok, pgm_ok, prt_ok, lock_ok;
    logic             tmr_load, tmr_run, tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    logic             arr_we;
    logic [IDX_W-1:0] arr_idx;
    logic [IDX_W-1:0] wr_idx;
    logic             wr_in_region;
    logic [PW-1:0]    pulse_nx;
    logic [DATA_W-1:0] arr_word;

    hprot_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr    (addr),
        .wdata   (wdata),
        .cyc1_ok (cyc1_ok),
        .cyc2_ok (cyc2_ok),
        .pgm_ok  (pgm_ok),
        .prt_ok  (prt_ok),
        .lock_ok (lock_ok)
    );

    hprot_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (tmr_run),
        .zero     (tmr_zero)
    );

    always_comb begin
        wr_idx       = addr[IDX_W-1:0];
        wr_in_region = ({1'b0, wr_idx} < REG_LIM);
        pulse_nx     = (ctl_q.pulses == PULSE_LIM) ? ctl_q.pulses : ctl_q.pulses + 1'b1;
        tmr_run      = (ctl_q.st == S_PGM_RUN) || (ctl_q.st == S_PRT_RUN);
    end

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        arr_we   = 1'b0;
        if (!mode_en) begin
            ctl_d.st = S_IDLE;
        end else begin
            unique case (ctl_q.st)
                S_IDLE: begin
                    if (wr_en && cyc1_ok) ctl_d.st = S_UL1;
                end
                S_UL1: begin
                    if (wr_en) ctl_d.st = cyc2_ok ? S_UL2 : S_IDLE;
                end
                S_UL2: begin
                    if (wr_en) begin
                        if (pgm_ok)      ctl_d.st = S_PGM_ARG;
                        else if (prt_ok) ctl_d.st = S_PRT_ARG;
                        else             ctl_d.st = S_IDLE;
                    end
                end
                S_PGM_ARG: begin
                    if (wr_en) begin
                        ctl_d.tgt_idx = wr_idx;
                        ctl_d.tgt_val = wdata;
                        if (ctl_q.prot && wr_in_region) begin
                            ctl_d.st = S_IDLE;
                        end else begin
                            ctl_d.st = S_PGM_RUN;
                            tmr_load = 1'b1;
                            tmr_val  = CNT_W'(PROG_CYCLES - 1);
                        end
                    end
                end
                S_PRT_ARG, S_PRT_VFY: begin
                    if (wr_en) begin
                        if (lock_ok) begin
                            ctl_d.st = S_PRT_RUN;
                            tmr_load = 1'b1;
                            tmr_val  = CNT_W'(PRT_LEN - 1);
                        end else begin
                            ctl_d.st = S_IDLE;
                        end
                    end
                end
                S_PGM_RUN: begin
                    if (tmr_zero) begin
                        arr_we   = 1'b1;
                        ctl_d.st = S_IDLE;
                    end
                end
                S_PRT_RUN: begin
                    if (tmr_zero) begin
                        ctl_d.pulses = pulse_nx;
                        ctl_d.prot   = ctl_q.prot | (pulse_nx == PULSE_LIM);
                        ctl_d.st     = S_PRT_ARMED;
                    end
                end
                S_PRT_ARMED: begin
                    if (wr_en) ctl_d.st = lock_ok ? S_PRT_VFY : S_IDLE;
                end
                default: ctl_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st      <= S_IDLE;
            ctl_q.pulses  <= '0;
            ctl_q.prot    <= 1'b0;
            ctl_q.tgt_idx <= '0;
            ctl_q.tgt_val <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign arr_idx = ctl_q.tgt_idx;

    hprot_array #(.WORDS(MEM_WORDS), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .widx  (arr_idx),
        .wval  (ctl_q.tgt_val),
        .ridx  (wr_idx),
        .rword (arr_word)
    );

    hprot_rdport #(.DATA_W(DATA_W)) u_rdport (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .show_poll (tmr_run),
        .show_vfy  (ctl_q.st == S_PRT_VFY),
        .poll_bit  ((ctl_q.st == S_PGM_RUN) ? ~ctl_q.tgt_val[7] : 1'b0),
        .vfy_bit   (ctl_q.prot),
        .word      (arr_word),
        .rdata     (rdata)
    );

    assign busy        = tmr_run;
    assign protect_bit = ctl_q.prot;

endmodule

// File: rtl/hprot_seq_chk.sv
module hprot_seq_chk #(
    parameter int IDX_W        = 4,
    parameter int REGION_WORDS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_en,
    input logic             rd_en,
    input logic             busy,
    input logic             protect_bit,
    input logic [15:0]      rdata,
    input logic             arr_we,
    input logic [IDX_W-1:0] arr_idx
);
    AST_IDLE_WITHOUT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> !busy) else $error("busy without mode"); // R2

    AST_WRITE_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> mode_en) else $error("array write without mode"); // R2

    AST_PROT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        protect_bit |=> protect_bit) else $error("protect bit cleared"); // R9

    AST_PROT_AT_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(protect_bit) |-> $fell(busy)) else $error("protect set outside pulse end"); // R9

    AST_POLL_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en) |=> ((rdata & 16'hFF3F) == 16'h0000)) else $error("status word format"); // R5

    AST_REGION_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && protect_bit) |-> ({1'b0, arr_idx} >= (IDX_W+1)'(REGION_WORDS)))
        else $error("locked region written"); // R10

endmodule

bind hprot_seq hprot_seq_chk #(.IDX_W(IDX_W), .REGION_WORDS(REGION_WORDS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_en     (mode_en),
    .rd_en       (rd_en),
    .busy        (busy),
    .protect_bit (protect_bit),
    .rdata       (rdata),
    .arr_we      (arr_we),
    .arr_idx     (arr_idx)
);

// File: tb/hprot_seq_tb.sv
module hprot_seq_tb;
    localparam int PGM_LEN = 16;
    localparam int PRT_LEN = 100 * 150;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [10:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        busy;
    logic        protect_bit;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hprot_seq u_dut (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy), .protect_bit(protect_bit)
    );

    typedef struct packed {
        logic [10:0] a;
        logic [15:0] d;
        logic [15:0] e;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{11'h010, 16'h1234, 16'h1234},
        '{11'h020, 16'hFF00, 16'h1200},
        '{11'h005, 16'hA5A5, 16'hA5A5},
        '{11'h009, 16'h0F0F, 16'h0F0F},
        '{11'h015, 16'hFFFF, 16'hA5A5},
        '{11'h07F, 16'h8001, 16'h8001}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic program_word(input logic [10:0] a, input logic [15:0] d);
        wr(11'h555, 16'h00AA);
        wr(11'h2AA, 16'h0055);
        wr(11'h555, 16'h00A0);
        wr(a, d);
    endtask

    task automatic protect_start();
        wr(11'h555, 16'h00AA);
        wr(11'h2AA, 16'h0055);
        wr(11'h555, 16'h0060);
        wr(11'h000, 16'h0048);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_err++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            finish_run();
        end
    end

    initial begin
        logic [15:0] v, v2;
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", busy, 0);
        check("R1 protect_bit", protect_bit, 0);
        check("R1 rdata", rdata, 0);
        rst_n = 1'b1;
        mode_en = 1'b1;
        rd(11'h003, v);
        check("R1 erased word", v, 16'hFFFF);

        // R4 R6 R11: vector table of program operations
        for (int i = 0; i < 6; i++) begin
            program_word(VECS[i].a, VECS[i].d);
            busy_len(n);
            check("R4 program busy length", n, PGM_LEN);
            rd(VECS[i].a, v);
            check("R4 R11 program result", v, VECS[i].e);
        end

        // R5: status reads during program, writes ignored
        program_word(11'h002, 16'h00F0);
        rd(11'h002, v);
        rd(11'h002, v2);
        check("R5 status bits first", v & 16'hFFBF, 16'h0000);
        check("R5 status bits second", v2 & 16'hFFBF, 16'h0000);
        check("R5 toggle", (v ^ v2) & 16'h0040, 16'h0040);
        wr(11'h002, 16'h0000);
        check("R5 still busy", busy, 1);
        busy_len(n);
        rd(11'h002, v);
        check("R5 write during busy ignored", v, 16'h00F0);

        // R3: mismatched prefix returns idle
        wr(11'h555, 16'h00AA);
        wr(11'h2AA, 16'h0055);
        wr(11'h555, 16'h0090);
        wr(11'h003, 16'h0000);
        check("R3 bad command no busy", busy, 0);
        wr(11'h555, 16'h00AA);
        wr(11'h2AB, 16'h0055);
        wr(11'h555, 16'h00A0);
        wr(11'h003, 16'h0000);
        check("R3 bad address no busy", busy, 0);
        rd(11'h003, v);
        check("R3 word untouched", v, 16'hFFFF);

        // R2: mode inactive
        mode_en = 1'b0;
        program_word(11'h003, 16'h0000);
        check("R2 no busy without mode", busy, 0);
        mode_en = 1'b1;
        rd(11'h003, v);
        check("R2 word untouched", v, 16'hFFFF);
        program_word(11'h004, 16'h0000);
        check("R2 busy before abort", busy, 1);
        mode_en = 1'b0;
        @(negedge clk);
        check("R2 abort clears busy", busy, 0);
        mode_en = 1'b1;
        rd(11'h004, v);
        check("R2 aborted program no effect", v, 16'hFFFF);

        // R7 R8 R9: protect with one failed verify then retry
        protect_start();
        busy_len(n);
        check("R7 pulse length", n, PRT_LEN);
        check("R9 not yet protected", protect_bit, 0);
        wr(11'h000, 16'h0048);
        rd(11'h000, v);
        check("R8 R9 verify fail", v, 16'h0000);
        wr(11'h000, 16'h0048);
        check("R9 retry busy", busy, 1);
        busy_len(n);
        check("R9 retry pulse length", n, PRT_LEN);
        check("R9 protected", protect_bit, 1);
        wr(11'h000, 16'h0048);
        rd(11'h000, v);
        check("R8 verify pass", v, 16'h0001);

        // R10: region locked
        program_word(11'h001, 16'h0000);
        check("R10 no busy", busy, 0);
        rd(11'h001, v);
        check("R10 word untouched", v, 16'hFFFF);
        rd(11'h010, v);
        check("R10 word0 kept", v, 16'h1200);

        // R6: outside region still programmable
        program_word(11'h009, 16'h0F00);
        busy_len(n);
        rd(11'h009, v);
        check("R6 outside region programmed", v, 16'h0F00);

        // R12: wrong arming write returns idle
        protect_start();
        busy_len(n);
        wr(11'h000, 16'h0011);
        rd(11'h010, v);
        check("R12 read returns array data", v, 16'h1200);
        check("R9 protect stays", protect_bit, 1);

        finish_run();
    end

endmodule